// File: doc/BRIEF.md
# Bit-Serial Multiplexer ALU

This block is the arithmetic and logic unit of a small processor whose datapath moves bytes one bit at a time. A start pulse captures a 3-bit function code from the low bits of the internal data bus. It also loads the carry flag with the value that operation needs. Over the next eight clock cycles the datapath presents one bit of each operand per cycle, least significant bit first. In the same cycle the block returns the matching result bit, which goes straight to the datapath's serial shift input.

Each result bit comes from a small per-bit multiplexer table. There is no parallel adder. The carry, or borrow-not, travels from one bit to the next through the carry-flag register. When the last bit has been processed, that register holds the final flag. A one-cycle done pulse marks the end of the operation. For a right shift, the datapath puts the next-higher bit of operand A on the B lane. This needs nothing extra, because the datapath shift register has that tap available at the same time as bit 0.

Top module: `serial_mux_alu`

## Requirements
- R1: When a start is accepted, the block captures the function code from `bus_lo` on that edge (0 pass A, 1 OR, 2 AND, 3 XOR, 4 add, 5 B minus A, 6 shift right, 7 A minus B). Changes on `bus_lo` after that edge have no effect until the operation ends.
- R2: `start` is accepted only while the block is idle. A `start` raised during an operation changes neither the result bits, the flag nor the done timing.
- R3: `res_valid` is high for exactly eight cycles, beginning in the cycle after the accepting edge. `done` is high for exactly the one cycle that follows the last bit.
- R4: For codes 0 to 3, `res_bit` is A, A|B, A&B or A^B, and `carry_flag` holds its prior value from the start through the end of the operation.
- R5: For code 4, the flag is cleared on start. Each bit is A^B^flag, and the flag takes the majority of A, B and the flag. After the eighth bit, the flag holds the carry out of the byte.
- R6: For codes 7 and 5, the flag is set on start and the subtrahend is inverted before the add. After the eighth bit, the flag is 1 when no borrow occurred and 0 when one did.
- R7: For code 6, the flag keeps its prior value through bit 0 and then takes bit 0 of A. Result bits 0 to 6 equal the B lane, which carries A's next-higher bit, and result bit 7 is 0.
- R8: While `rst` is high, and after it falls, `res_valid`, `done`, `res_bit` and `carry_flag` are 0.
- R9: Each result bit depends combinationally on the operand bits of the same cycle, so the bit is valid in the same cycle the operands are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when idle |
| bus_lo | input | 3 | Low bits of the internal data bus, holding the function code |
| op_a | input | 1 | Operand A bit for the current step |
| op_b | input | 1 | Operand B bit, or A's next-higher bit during a shift |
| res_bit | output | 1 | Result bit for the datapath serial shift input |
| res_valid | output | 1 | High during the eight bit-times of an operation |
| done | output | 1 | One-cycle pulse after the last bit |
| carry_flag | output | 1 | Carry flag (carry, borrow-not, or shifted-out bit) |

## Verification
A start sampled at an edge makes `res_valid` high from the next cycle onward. The bench drives operands after a falling edge and reads `res_bit` one time step later, inside that same cycle, because the result is combinational. The flag value seen during bit 0 shows the preload, or the retained value for logic codes and shifts. The final flag and `done` are due in the cycle after the eighth bit edge, and the bench reads them at the falling edge of that cycle. It then checks one falling edge later that `done` has dropped.

// File: rtl/serial_mux_alu_pkg.sv
package serial_mux_alu_pkg;

    localparam int FN_W = 3;

    typedef enum logic [FN_W-1:0] {
        FN_PASS  = 3'd0,
        FN_OR    = 3'd1,
        FN_AND   = 3'd2,
        FN_XOR   = 3'd3,
        FN_ADD   = 3'd4,
        FN_SUBBA = 3'd5,
        FN_SHR   = 3'd6,
        FN_SUBAB = 3'd7
    } alu_fn_e;

    // Per-step inputs to the bit multiplexer
    typedef struct packed {
        logic a;
        logic b;
        logic cin;
        logic first;
        logic last;
    } bit_in_s;

    // Per-step outputs of the bit multiplexer
    typedef struct packed {
        logic res;
        logic cout;
        logic cwrite;
    } bit_out_s;

    // Value the flag takes when an operation starts
    function automatic logic flag_preload(alu_fn_e f, logic cur);
        logic v;
        case (f)
            FN_ADD:            v = 1'b0;
            FN_SUBAB, FN_SUBBA: v = 1'b1;
            default:           v = cur;
        endcase
        return v;
    endfunction

    function automatic logic maj3(logic x, logic y, logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/alu_fn_latch.sv
module alu_fn_latch
    import serial_mux_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [FN_W-1:0] code_in,
    output alu_fn_e         fn_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fn_q <= FN_PASS;
        end else if (load) begin
            fn_q <= alu_fn_e'(code_in);
        end
    end
endmodule

// File: rtl/alu_step_seq.sv
module alu_step_seq #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic first,
    output logic last,
    output logic done
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] step_q;
    logic             busy_q;
    logic             done_q;

    assign accept = start & ~busy_q;
    assign busy   = busy_q;
    assign first  = busy_q & (step_q == '0);
    assign last   = busy_q & (step_q == LAST_STEP);
    assign done   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                step_q <= '0;
            end else if (busy_q) begin
                if (step_q == LAST_STEP) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/alu_bit_mux.sv
module alu_bit_mux
    import serial_mux_alu_pkg::*;
(
    input  alu_fn_e  fn,
    input  bit_in_s  din,
    output bit_out_s dout
);
    logic add_x;
    logic add_y;

    // Operand steering for the adder path: subtrahend inverted
    always_comb begin
        case (fn)
            FN_SUBAB: begin add_x = din.a; add_y = ~din.b; end
            FN_SUBBA: begin add_x = din.b; add_y = ~din.a; end
            default:  begin add_x = din.a; add_y = din.b;  end
        endcase
    end

    always_comb begin
        dout.res    = 1'b0;
        dout.cout   = din.cin;
        dout.cwrite = 1'b0;
        case (fn)
            FN_PASS: dout.res = din.a;
            FN_OR:   dout.res = din.a | din.b;
            FN_AND:  dout.res = din.a & din.b;
            FN_XOR:  dout.res = din.a ^ din.b;
            FN_ADD, FN_SUBAB, FN_SUBBA: begin
                dout.res    = add_x ^ add_y ^ din.cin;
                dout.cout   = maj3(add_x, add_y, din.cin);
                dout.cwrite = 1'b1;
            end
            FN_SHR: begin
                dout.res    = din.last ? 1'b0 : din.b;
                dout.cout   = din.a;
                dout.cwrite = din.first;
            end
            default: dout.res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_carry_reg.sv
module alu_carry_reg (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic load_val,
    input  logic step_en,
    input  logic write,
    input  logic cout,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (load) begin
            flag_q <= load_val;
        end else if (step_en && write) begin
            flag_q <= cout;
        end
    end
endmodule

// File: rtl/serial_mux_alu.sv
module serial_mux_alu
    import serial_mux_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [FN_W-1:0] bus_lo,
    input  logic            op_a,
    input  logic            op_b,
    output logic            res_bit,
    output logic            res_valid,
    output logic            done,
    output logic            carry_flag
);
    alu_fn_e  fn_q;
    bit_in_s  bin;
    bit_out_s bout;
    logic     accept;
    logic     busy;
    logic     first;
    logic     last;
    logic     flag_q;
    logic     preload_val;

    alu_fn_latch u_fn (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .code_in (bus_lo),
        .fn_q    (fn_q)
    );

    alu_step_seq #(.DATA_W(DATA_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .first  (first),
        .last   (last),
        .done   (done)
    );

    assign bin.a     = op_a;
    assign bin.b     = op_b;
    assign bin.cin   = flag_q;
    assign bin.first = first;
    assign bin.last  = last;

    alu_bit_mux u_mux (
        .fn   (fn_q),
        .din  (bin),
        .dout (bout)
    );

    assign preload_val = flag_preload(alu_fn_e'(bus_lo), flag_q);

    alu_carry_reg u_cy (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (preload_val),
        .step_en  (busy),
        .write    (bout.cwrite),
        .cout     (bout.cout),
        .flag_q   (flag_q)
    );

    assign res_bit    = busy & bout.res;
    assign res_valid  = busy;
    assign carry_flag = flag_q;
endmodule

// File: rtl/serial_mux_alu_chk.sv
module serial_mux_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       res_bit,
    input logic       res_valid,
    input logic       done,
    input logic       carry_flag,
    input logic [2:0] fn_q
);
    localparam int CW = $clog2(DATA_W + 1) + 1;

    logic [CW-1:0] run_len;
    logic          prev_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len    <= '0;
            prev_valid <= 1'b0;
        end else begin
            prev_valid <= res_valid;
            if (res_valid) begin
                run_len <= prev_valid ? run_len + 1'b1 : CW'(1);
            end
        end
    end

    // R3: done is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: done arrives only after exactly DATA_W valid bit-times
    a_r3_done_after_len: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len == CW'(DATA_W)) && !res_valid);

    // R3: the end of a valid window is marked by done
    a_r3_fall_done: assert property (@(posedge clk) disable iff (rst)
        $fell(res_valid) |-> done);

    // R2: a valid window starts only from a start request
    a_r2_rise_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> $past(start));

    // R1: function code is held steady through an operation
    a_r1_fn_stable: assert property (@(posedge clk) disable iff (rst)
        (res_valid && prev_valid) |-> $stable(fn_q));

    // R4: logic codes leave the flag alone
    a_r4_logic_flag: assert property (@(posedge clk) disable iff (rst)
        (res_valid && fn_q < 3'd4) |=> $stable(carry_flag));

    // R5: add starts with a cleared flag
    a_r5_add_preload: assert property (@(posedge clk) disable iff (rst)
        ($rose(res_valid) && fn_q == 3'd4) |-> !carry_flag);

    // R6: both subtractions start with the flag set
    a_r6_sub_preload: assert property (@(posedge clk) disable iff (rst)
        ($rose(res_valid) && (fn_q == 3'd5 || fn_q == 3'd7)) |-> carry_flag);

    // R7: top result bit of a right shift is zero
    a_r7_shr_msb: assert property (@(posedge clk) disable iff (rst)
        (res_valid && fn_q == 3'd6 && run_len == CW'(DATA_W - 1) && prev_valid)
            |-> !res_bit);

    // R8: nothing is driven while idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_bit);
endmodule

bind serial_mux_alu serial_mux_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .res_bit    (res_bit),
    .res_valid  (res_valid),
    .done       (done),
    .carry_flag (carry_flag),
    .fn_q       (fn_q)
);

// File: tb/serial_mux_alu_test.sv
module serial_mux_alu_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] bus_lo = 3'd0;
    logic       op_a = 1'b0;
    logic       op_b = 1'b0;
    logic       res_bit;
    logic       res_valid;
    logic       done;
    logic       carry_flag;

    int errors = 0;
    int checks = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    serial_mux_alu #(.DATA_W(8)) uut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .bus_lo     (bus_lo),
        .op_a       (op_a),
        .op_b       (op_b),
        .res_bit    (res_bit),
        .res_valid  (res_valid),
        .done       (done),
        .carry_flag (carry_flag)
    );

    // {fn, a, b, result, final flag, flag during bit 0}
    localparam int NV = 13;
    localparam logic [28:0] VEC [NV] = '{
        {3'd4, 8'h3C, 8'h0F, 8'h4B, 1'b0, 1'b0},
        {3'd4, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},
        {3'd7, 8'h50, 8'h20, 8'h30, 1'b1, 1'b1},
        {3'd7, 8'h10, 8'h20, 8'hF0, 1'b0, 1'b1},
        {3'd5, 8'h05, 8'h03, 8'hFE, 1'b0, 1'b1},
        {3'd5, 8'h10, 8'h20, 8'h10, 1'b1, 1'b1},
        {3'd1, 8'hA0, 8'h0C, 8'hAC, 1'b1, 1'b1},
        {3'd2, 8'hF0, 8'h3C, 8'h30, 1'b1, 1'b1},
        {3'd3, 8'hFF, 8'h0F, 8'hF0, 1'b1, 1'b1},
        {3'd0, 8'h5A, 8'hC3, 8'h5A, 1'b1, 1'b1},
        {3'd6, 8'h81, 8'h00, 8'h40, 1'b1, 1'b1},
        {3'd6, 8'h02, 8'h00, 8'h01, 1'b0, 1'b1},
        {3'd3, 8'hAA, 8'h55, 8'hFF, 1'b0, 1'b0}
    };

    function automatic string fn_tag(logic [2:0] f);
        case (f)
            3'd4:       return "R5";
            3'd5, 3'd7: return "R6";
            3'd6:       return "R7";
            default:    return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp,
                         input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Called right after a falling edge; returns after the cycle in which done is due
    task automatic run_op(input logic [2:0] fn, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] exp_res, input logic exp_flag,
                          input logic exp_pf, input logic poke);
        logic [7:0] got;
        logic       valid_ok;
        string      tag;
        tag = fn_tag(fn);
        got = '0;
        valid_ok = 1'b1;
        start  = 1'b1;
        bus_lo = fn;
        @(negedge clk);
        start  = 1'b0;
        bus_lo = ~fn;                      // R1: later bus values must not matter
        for (int k = 0; k < 8; k++) begin
            op_a = a[k];
            if (fn == 3'd6) op_b = (k < 7) ? a[k+1] : 1'b1;
            else            op_b = b[k];
            if (poke && k == 3) begin
                start  = 1'b1;             // R2: start while busy
                bus_lo = 3'd4;
            end else begin
                start  = 1'b0;
            end
            #1;
            got[k] = res_bit;              // R9: same-cycle result
            if (res_valid !== 1'b1) valid_ok = 1'b0;
            if (k == 0) check(tag, {7'd0, carry_flag}, {7'd0, exp_pf}, "flag during bit 0");
            if (k == 0) check("R3", {7'd0, done}, 8'd0, "done low in bit 0");
            @(negedge clk);
        end
        start = 1'b0;
        op_a  = 1'b0;
        op_b  = 1'b0;
        check(tag, got, exp_res, "result byte");
        check(tag, {7'd0, carry_flag}, {7'd0, exp_flag}, "final flag");
        check("R3", {7'd0, valid_ok}, 8'd1, "valid held for eight bits");
        check("R3", {7'd0, done}, 8'd1, "done after last bit");
        check("R3", {7'd0, res_valid}, 8'd0, "valid dropped after last bit");
        @(negedge clk);
        check("R3", {7'd0, done}, 8'd0, "done one cycle only");
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [28:0] v;
        repeat (3) @(negedge clk);
        // R8: reset state, also with start asserted during reset
        start = 1'b1;
        op_a  = 1'b1;
        op_b  = 1'b1;
        @(negedge clk);
        check("R8", {5'd0, res_valid, done, carry_flag}, 8'd0, "outputs in reset");
        check("R8", {7'd0, res_bit}, 8'd0, "res_bit in reset");
        start = 1'b0;
        rst   = 1'b0;
        @(negedge clk);
        check("R8", {5'd0, res_valid, done, carry_flag}, 8'd0, "outputs after reset");
        check("R8", {7'd0, res_bit}, 8'd0, "res_bit idle with operands high");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            run_op(v[28:26], v[25:18], v[17:10], v[9:2], v[1], v[0], 1'b0);
        end

        // R2: start during an add is ignored; flag left at 1 by 0x80+0x80
        run_op(3'd4, 8'h80, 8'h80, 8'h00, 1'b1, 1'b0, 1'b1);
        // R2 / R4: start raised during a logic op must not preload the flag
        run_op(3'd1, 8'h0F, 8'h30, 8'h3F, 1'b1, 1'b1, 1'b1);
        // R7: right shift starting with flag 1, bit 0 of A is 0
        run_op(3'd6, 8'hFE, 8'h00, 8'h7F, 1'b0, 1'b1, 1'b0);
        // R6: equal operands give no borrow
        run_op(3'd7, 8'h77, 8'h77, 8'h00, 1'b1, 1'b1, 1'b0);

        // R8: reset mid-operation clears everything
        start  = 1'b1;
        bus_lo = 3'd5;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8", {5'd0, res_valid, done, carry_flag}, 8'd0, "reset during operation");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule